// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Conditioner

The block takes a slow clock as an ordinary data input and rebuilds it inside a fast oversampling clock domain. The rebuilt clock has the same frequency as the incoming one, and its high time is set by a run-time value. The duty cycle of the incoming clock has no effect on the result. Each rising edge of the synchronized input flips a toggle bit, which gives a half-rate square wave with exactly equal halves. That wave is combined by XOR with a copy of itself taken from a tapped shift register. The XOR is high for exactly as many fast cycles as the tap is deep, so the input rate comes back and the high time equals the selected delay.

The block also counts the fast cycles between successive input rising edges and reports the count, so software can turn a wanted percentage into a delay value. A new delay value is captured only on an input rising edge, which keeps runt pulses out of the output. A delay of zero parks the output low. A delay that reaches the measured period parks it high.

Top module: `dcc_duty_conditioner`

## Requirements
- R1: While `rst` is high, and on the first fast-clock edge after it is asserted, `clk_out` is 0 and `period` is 0.
- R2: After reset, `clk_out` stays 0 until two rising edges of `clk_in` have been detected, even with a non-zero `delay_sel`.
- R3: Once armed, `clk_out` has the same period, in fast cycles, as `clk_in` for any input duty cycle (checked at 20%, 50% and 80%).
- R4: For a captured delay d with 0 < d < P, where P is the input period in fast cycles and d ≤ MAX_DELAY, each `clk_out` high pulse lasts exactly d fast cycles.
- R5: A captured delay of 0 holds `clk_out` at 0.
- R6: A captured delay d ≥ P holds `clk_out` at 1.
- R7: A captured delay above MAX_DELAY (64 by default) but below P is treated as MAX_DELAY.
- R8: `period` gives the number of fast cycles between the two most recent rising edges of `clk_in`. It changes only when a new rising edge is detected.
- R9: A new `delay_sel` is captured only when a rising edge of `clk_in` is detected. A change made during a high pulse leaves that pulse's length unchanged and applies from the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_in | input | 1 | Slow clock to condition, treated as asynchronous data |
| delay_sel | input | $clog2(MAX_DELAY+1) | Wanted high time in fast cycles |
| clk_out | output | 1 | Registered regenerated clock |
| period | output | PERIOD_W | Measured input period in fast cycles |

## Verification
If the toggle bit or the edge detector goes wrong, the output period stops matching the input, which shows within one or two input periods. A wrong tap selection or a fault in the shift register changes the measured high time on the very next pulse. If the capture register takes a new value at the wrong time, the pulse in progress is cut or stretched. A broken saturation compare or a broken arming sequence shows as the output staying high or staying low over a whole input period, where the requirements expect the opposite level.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    ARM_IDLE  = 2'd0,
    ARM_ONE   = 2'd1,
    ARM_READY = 2'd2
  } arm_e;
endpackage

// File: rtl/dcc_edge_sync.sv
module dcc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      rise <= 1'b0;
    end else begin
      prev <= chain[SYNC_STAGES-1];
      rise <= chain[SYNC_STAGES-1] & ~prev;
    end
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst) rise |=> !rise); // R3
endmodule

// File: rtl/dcc_period_meter.sv
module dcc_period_meter #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise,
  output logic [PERIOD_W-1:0] period
);
  localparam logic [PERIOD_W-1:0] CNT_MAX = '1;

  logic [PERIOD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      period <= '0;
    end else if (rise) begin
      period <= cnt;
      cnt    <= PERIOD_W'(1);
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst) !rise |=> $stable(period)); // R8
endmodule

// File: rtl/dcc_tap_delay.sv
module dcc_tap_delay #(
  parameter int MAX_DELAY = 64,
  parameter int SEL_W     = $clog2(MAX_DELAY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);
  localparam int IDX_W = (MAX_DELAY > 1) ? $clog2(MAX_DELAY) : 1;

  logic [MAX_DELAY-1:0] line;
  logic [IDX_W-1:0]     idx;

  generate
    if (MAX_DELAY == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) line <= '0;
        else     line <= din;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) line <= '0;
        else     line <= {line[MAX_DELAY-2:0], din};
      end
    end
  endgenerate

  always_comb begin
    if (sel == '0) idx = '0;
    else           idx = IDX_W'(sel - 1'b1);
  end

  assign dout = line[idx];
endmodule

// File: rtl/dcc_duty_conditioner.sv
module dcc_duty_conditioner
  import dcc_pkg::*;
#(
  parameter int MAX_DELAY   = 64,
  parameter int PERIOD_W    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(MAX_DELAY + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clk_in,
  input  logic [SEL_W-1:0]    delay_sel,
  output logic                clk_out,
  output logic [PERIOD_W-1:0] period
);
  localparam logic [SEL_W-1:0] SEL_CAP = SEL_W'(MAX_DELAY);

  logic             rise;
  logic             toggle;
  logic [SEL_W-1:0] cur_d;
  logic [SEL_W-1:0] eff_d;
  logic             tapped;
  logic             out_next;
  logic             armed;
  arm_e             arm_state;

  dcc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (clk_in),
    .rise     (rise)
  );

  dcc_period_meter #(.PERIOD_W(PERIOD_W)) u_meter (
    .clk    (clk),
    .rst    (rst),
    .rise   (rise),
    .period (period)
  );

  assign eff_d = (cur_d > SEL_CAP) ? SEL_CAP : cur_d;

  dcc_tap_delay #(.MAX_DELAY(MAX_DELAY), .SEL_W(SEL_W)) u_line (
    .clk  (clk),
    .rst  (rst),
    .din  (toggle),
    .sel  (eff_d),
    .dout (tapped)
  );

  assign armed = (arm_state == ARM_READY);

  always_comb begin
    if (cur_d == '0)                      out_next = 1'b0;
    else if (PERIOD_W'(cur_d) >= period)  out_next = 1'b1;
    else                                  out_next = toggle ^ tapped;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      toggle    <= 1'b0;
      cur_d     <= '0;
      arm_state <= ARM_IDLE;
      clk_out   <= 1'b0;
    end else begin
      clk_out <= armed & out_next;
      if (rise) begin
        toggle <= ~toggle;
        cur_d  <= delay_sel;
        case (arm_state)
          ARM_IDLE: arm_state <= ARM_ONE;
          ARM_ONE:  arm_state <= ARM_READY;
          default:  arm_state <= ARM_READY;
        endcase
      end
    end
  end

  AST_UNARMED_LOW: assert property (@(posedge clk) disable iff (rst) !armed |=> !clk_out); // R2
  AST_ZERO_DELAY:  assert property (@(posedge clk) disable iff (rst) (cur_d == '0) |=> !clk_out); // R5
  AST_SAT_HIGH:    assert property (@(posedge clk) disable iff (rst)
                     (armed && cur_d != '0 && PERIOD_W'(cur_d) >= period) |=> clk_out); // R6
  AST_SEL_HOLD:    assert property (@(posedge clk) disable iff (rst) !rise |=> $stable(cur_d)); // R9
  AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (rst) rise |=> (toggle != $past(toggle))); // R3
endmodule

// File: tb/sim_dcc_duty_conditioner.sv
`timescale 1ns/1ps
module sim_dcc_duty_conditioner;
  localparam int MAXD = 64;
  localparam int PW   = 16;
  localparam int SW   = $clog2(MAXD + 1);
  localparam int NV   = 6;
  // input period, input high cycles, delay_sel, expected output high cycles
  localparam int VEC [NV][4] = '{
    '{40,  8, 20, 20},
    '{40, 32, 20, 20},
    '{40, 20, 12, 12},
    '{50, 10, 35, 35},
    '{30, 15, 29, 29},
    '{40, 20,  1,  1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_in;
  logic [SW-1:0] delay_sel = '0;
  logic          clk_out;
  logic [PW-1:0] period;

  int checks = 0;
  int fails  = 0;
  int gen_per = 40;
  int gen_hi  = 20;
  bit gen_en  = 1'b0;

  always #2 clk = ~clk;

  dcc_duty_conditioner #(.MAX_DELAY(MAXD), .PERIOD_W(PW)) u0 (
    .clk       (clk),
    .rst       (rst),
    .clk_in    (clk_in),
    .delay_sel (delay_sel),
    .clk_out   (clk_out),
    .period    (period)
  );

  always begin
    if (gen_en) begin
      clk_in = 1'b1;
      repeat (gen_hi) @(negedge clk);
      clk_in = 1'b0;
      repeat (gen_per - gen_hi) @(negedge clk);
    end else begin
      clk_in = 1'b0;
      @(negedge clk);
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_out === 1'b1) h++;
    end
  endtask

  task automatic measure(output int hi, output int per);
    int guard;
    guard = 0;
    hi = 0;
    per = 0;
    @(negedge clk);
    while (clk_out !== 1'b0 && guard < 1000) begin @(negedge clk); guard++; end
    while (clk_out !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    while (clk_out === 1'b1 && guard < 3000) begin hi++; @(negedge clk); guard++; end
    per = hi;
    while (clk_out === 1'b0 && guard < 4000) begin per++; @(negedge clk); guard++; end
  endtask

  initial begin
    int h, p, n;
    // R1: reset state
    wait_cycles(5);
    check("R1 clk_out in reset", int'(clk_out), 0);
    check("R1 period in reset", int'(period), 0);
    rst = 1'b0;
    delay_sel = SW'(20);
    // R2: no output while clk_in is quiet
    count_high(10, h);
    check("R2 quiet input", h, 0);
    gen_per = 40;
    gen_hi  = 20;
    gen_en  = 1'b1;
    // R2: only one input edge in this window
    count_high(40, h);
    check("R2 one edge seen", h, 0);

    // R3 R4 R8: vector table over input duty cycles and delays
    for (int v = 0; v < NV; v++) begin
      gen_per   = VEC[v][0];
      gen_hi    = VEC[v][1];
      delay_sel = SW'(VEC[v][2]);
      wait_cycles(4 * VEC[v][0]);
      measure(h, p);
      check("R4 high time", h, VEC[v][3]);
      check("R3 output period", p, VEC[v][0]);
      check("R8 measured period", int'(period), VEC[v][0]);
    end

    // R5: zero delay
    gen_per = 40;
    gen_hi  = 20;
    delay_sel = '0;
    wait_cycles(120);
    count_high(80, h);
    check("R5 zero delay high samples", h, 0);

    // R6: delay equal to and above the period
    delay_sel = SW'(40);
    wait_cycles(120);
    count_high(80, h);
    check("R6 delay equals period", h, 80);
    delay_sel = SW'(60);
    wait_cycles(120);
    count_high(80, h);
    check("R6 delay above period", h, 80);

    // R7: delay beyond line depth with a long input period
    gen_per = 100;
    gen_hi  = 50;
    delay_sel = SW'(80);
    wait_cycles(400);
    measure(h, p);
    check("R7 clamped high time", h, MAXD);
    check("R3 long period", p, 100);

    // R9: change delay_sel in the middle of a pulse
    gen_per = 40;
    gen_hi  = 20;
    delay_sel = SW'(20);
    wait_cycles(200);
    n = 0;
    while (clk_out !== 1'b0) @(negedge clk);
    while (clk_out !== 1'b1) @(negedge clk);
    n = 1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (clk_out === 1'b1) n++;
    end
    delay_sel = SW'(5);
    @(negedge clk);
    while (clk_out === 1'b1) begin n++; @(negedge clk); end
    check("R9 pulse in progress kept", n, 20);
    measure(h, p);
    check("R9 next pulse uses new delay", h, 5);

    // R1: reset while running
    @(negedge clk);
    rst = 1'b1;
    wait_cycles(2);
    check("R1 clk_out after mid-run reset", int'(clk_out), 0);
    check("R1 period after mid-run reset", int'(period), 0);
    rst = 1'b0;

    finish_run();
  end
endmodule